// File: doc/BRIEF.md
# Current-Limit Fault Mode Sequencer

This block is the digital sequencer for the pass switch of a power limiter. It decides when the switch conducts, which current-limit multiplier the analog regulator applies, and when the fault indication is raised. It does this from a slow time-base tick and a set of comparator flags. The flags report overcurrent, severe overcurrent at twice the limit, output charged, overtemperature and temperature recovered. The analog regulation loops and the comparators stay outside. Every duration is a parameter counted in ticks, so a fast tick shortens a simulation and a slow tick gives real time.

After power-up or a fault reset, the sequencer waits a debounce interval and then turns the switch on. Each turn-on opens a short window in which a boosted limit applies, and a startup timeout runs alongside it. The fault-response mode holds at continuous until a start completes. At that point the two mode-select pins are sampled. Autoretry and latchoff modes turn the switch off after a blanking time of sustained overcurrent. Autoretry then waits thirty blanking times before it tries again, and latchoff stays off until a reset pulse. Continuous mode never turns the switch off for overcurrent. In every mode, a severe overcurrent forces the switch off at once, and an overtemperature forces it off until the die has cooled.

Top module: `ilim_fault_seq`

## Requirements
- R1: On reset, and in the cycle after a one-cycle `clr` pulse in any state, `sw_on` and `fault` are 0 and `lim_code` is 00. After DEB_T ticks the switch turns on. `clr` also forces the mode to continuous.
- R2: On every turn-on, `lim_code` carries BOOST_CODE for the first STI_T ticks and 00 after that. The codes are 00 for 1x, 01 for 1.5x and 10 for 2x. While the switch is off, `lim_code` is 00.
- R3: If `charged` is never seen during the STO_T ticks after a turn-on, the switch turns off with `fault` high and stays off until `clr`.
- R4: The mode is continuous until a start completes. When a start ends with `charged` seen, the pins {sel2,sel1} are sampled: 00 selects latchoff, 01 selects autoretry, and 10 or 11 selects continuous.
- R5: In autoretry and latchoff modes, the switch turns off on the BLANK_T-th consecutive ticked cycle with overcurrent present. A ticked cycle with the switch on and no overcurrent clears the count.
- R6: In autoretry mode, the switch stays off for RETRY_MULT×BLANK_T ticks after blanking and then turns on again with the boosted window. The cycle repeats while the overcurrent persists.
- R7: In latchoff mode, the switch stays off after blanking until `clr`, whatever the inputs do.
- R8: In continuous mode, a sustained `oc` never turns the switch off, and `fault` follows `oc`.
- R9: While the switch is on, `oc2x` turns it off at the next edge in every mode. It turns on again after SEV_T ticks. In the two timed modes, the severe-off ticks count toward blanking, so in latchoff a persisting `oc2x` latches the switch off.
- R10: `ovt` turns the switch off. Latchoff then latches. Autoretry waits for `cool` and then the retry interval. Continuous waits for `cool` and then DEB_T ticks.
- R11: `fault` is high whenever the switch is held off by a severe-off, retry, overtemperature or latch, and whenever the switch is on with `oc` or `oc2x` present. It is low during the debounce after a reset.
- R12: All intervals advance only on cycles with `tick` high. While `tick` is low, an off switch stays off unless `cool` arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base enable; every interval counts these |
| oc | input | 1 | Current at or above the set limit |
| oc2x | input | 1 | Current above twice the set limit |
| charged | input | 1 | Output has reached the charged level |
| ovt | input | 1 | Die overtemperature |
| cool | input | 1 | Die has cooled below the recovery threshold |
| sel2 | input | 1 | Mode-select pin, upper bit |
| sel1 | input | 1 | Mode-select pin, lower bit |
| clr | input | 1 | One-cycle fault reset (enable toggle or input power cycle) |
| sw_on | output | 1 | Pass switch on |
| lim_code | output | 2 | Current-limit multiplier code (00 1x, 01 1.5x, 10 2x) |
| fault | output | 1 | Fault indication |

## Verification
A wrong internal state shows up mainly as an interval of the wrong length between transitions of `sw_on`, `lim_code` and `fault`. So the bench checks every output transition against both its expected value and the exact number of cycles since the previous transition. A blanking count that is not cleared, or a mode latched too early, gives an off edge a few cycles early or an unexpected off edge. A timer counting untick'd cycles cuts the retry interval short within the same window. A stale latch state appears as a missing restart after `clr`, caught at the next expected transition.

// File: rtl/lim_seq_pkg.sv
package lim_seq_pkg;

  typedef enum logic [2:0] {
    S_DEB   = 3'd0,
    S_START = 3'd1,
    S_RUN   = 3'd2,
    S_SEV   = 3'd3,
    S_RETRY = 3'd4,
    S_HOT   = 3'd5,
    S_LATCH = 3'd6
  } seq_st_t;

  typedef enum logic [1:0] {
    M_LATCH = 2'd0,
    M_RETRY = 2'd1,
    M_CONT  = 2'd2
  } fmode_t;

  localparam logic [1:0] LIM_1X   = 2'b00;
  localparam logic [1:0] LIM_1P5X = 2'b01;
  localparam logic [1:0] LIM_2X   = 2'b10;

  function automatic fmode_t decode_mode(input logic s2, input logic s1);
    if (s2)      return M_CONT;
    else if (s1) return M_RETRY;
    else         return M_LATCH;
  endfunction

endpackage

// File: rtl/seq_tick_timer.sv
module seq_tick_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  input  logic         tick,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_nx
);
  localparam logic [W-1:0] TOP = '1;

  always_comb begin
    if (restart)                 cnt_nx = '0;
    else if (tick && cnt != TOP) cnt_nx = cnt + 1'b1;
    else                         cnt_nx = cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt_nx;
  end
endmodule

// File: rtl/seq_blank_acc.sv
module seq_blank_acc #(
  parameter int BLANK_T = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic adv,
  input  logic tick,
  output logic expire
);
  localparam int BW = $clog2(BLANK_T + 1);
  localparam logic [BW-1:0] LAST = BW'(BLANK_T - 1);

  logic [BW-1:0] acc;

  assign expire = tick && adv && !clear && (acc == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear)          acc <= '0;
    else if (tick && adv)      acc <= (acc == LAST) ? '0 : acc + 1'b1;
  end
endmodule

// File: rtl/seq_mode_reg.sv
module seq_mode_reg
  import lim_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   clr,
  input  logic   load,
  input  logic   sel2,
  input  logic   sel1,
  output fmode_t mode
);
  always_ff @(posedge clk) begin
    if (rst || clr) mode <= M_CONT;
    else if (load)  mode <= decode_mode(sel2, sel1);
  end
endmodule

// File: rtl/ilim_fault_seq.sv
module ilim_fault_seq
  import lim_seq_pkg::*;
#(
  parameter int         DEB_T      = 6,
  parameter int         STI_T      = 4,
  parameter int         STO_T      = 16,
  parameter int         BLANK_T    = 5,
  parameter int         RETRY_MULT = 30,
  parameter int         SEV_T      = 3,
  parameter logic [1:0] BOOST_CODE = 2'b10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       oc,
  input  logic       oc2x,
  input  logic       charged,
  input  logic       ovt,
  input  logic       cool,
  input  logic       sel2,
  input  logic       sel1,
  input  logic       clr,
  output logic       sw_on,
  output logic [1:0] lim_code,
  output logic       fault
);
  localparam int RETRY_T = RETRY_MULT * BLANK_T;
  localparam int M1   = (STO_T > RETRY_T) ? STO_T : RETRY_T;
  localparam int M2   = (DEB_T > SEV_T) ? DEB_T : SEV_T;
  localparam int MAXT = (M1 > M2) ? M1 : M2;
  localparam int TW   = $clog2(MAXT + 1);

  localparam logic [TW-1:0] DEB_LAST   = TW'(DEB_T - 1);
  localparam logic [TW-1:0] STO_LAST   = TW'(STO_T - 1);
  localparam logic [TW-1:0] SEV_LAST   = TW'(SEV_T - 1);
  localparam logic [TW-1:0] RETRY_LAST = TW'(RETRY_T - 1);
  localparam logic [TW-1:0] BOOST_END  = TW'(STI_T);

  seq_st_t       st_q, st_n;
  fmode_t        mode_q;
  logic [TW-1:0] tmr, tmr_nx;
  logic          restart, blk_exp, blk_clr, blk_adv;
  logic          chg_q, on_q, on_n, timed, load_mode;

  assign on_q  = (st_q == S_START) || (st_q == S_RUN);
  assign on_n  = (st_n == S_START) || (st_n == S_RUN);
  assign timed = (mode_q != M_CONT);

  assign blk_adv = timed && ((on_q && (oc || oc2x)) || (st_q == S_SEV));
  assign blk_clr = clr || !(on_q || st_q == S_SEV) || (on_q && !oc && !oc2x);

  always_comb begin
    st_n = st_q;
    if (clr) begin
      st_n = S_DEB;
    end else begin
      unique case (st_q)
        S_DEB:   if (tick && tmr == DEB_LAST) st_n = S_START;
        S_START, S_RUN: begin
          if (ovt)
            st_n = (mode_q == M_LATCH) ? S_LATCH : S_HOT;
          else if (blk_exp)
            st_n = (mode_q == M_LATCH) ? S_LATCH : S_RETRY;
          else if (oc2x)
            st_n = S_SEV;
          else if (st_q == S_START && tick && tmr == STO_LAST)
            st_n = (chg_q || charged) ? S_RUN : S_LATCH;
        end
        S_SEV: begin
          if (blk_exp)
            st_n = (mode_q == M_LATCH) ? S_LATCH : S_RETRY;
          else if (tick && tmr == SEV_LAST)
            st_n = S_START;
        end
        S_RETRY: if (tick && tmr == RETRY_LAST) st_n = S_START;
        S_HOT:   if (cool) st_n = (mode_q == M_RETRY) ? S_RETRY : S_DEB;
        S_LATCH: st_n = S_LATCH;
        default: st_n = S_LATCH;
      endcase
    end
  end

  assign restart   = clr || (st_n != st_q);
  assign load_mode = !clr && (st_q == S_START) && (st_n == S_RUN);

  seq_tick_timer #(.W(TW)) u_tmr (
    .clk(clk), .rst(rst), .restart(restart), .tick(tick),
    .cnt(tmr), .cnt_nx(tmr_nx)
  );

  seq_blank_acc #(.BLANK_T(BLANK_T)) u_blk (
    .clk(clk), .rst(rst), .clear(blk_clr), .adv(blk_adv), .tick(tick),
    .expire(blk_exp)
  );

  seq_mode_reg u_mode (
    .clk(clk), .rst(rst), .clr(clr), .load(load_mode),
    .sel2(sel2), .sel1(sel1), .mode(mode_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= S_DEB;
      chg_q    <= 1'b0;
      sw_on    <= 1'b0;
      lim_code <= LIM_1X;
      fault    <= 1'b0;
    end else begin
      st_q <= st_n;
      if (st_n == S_START && st_q != S_START) chg_q <= 1'b0;
      else if (st_q == S_START && charged)    chg_q <= 1'b1;
      sw_on    <= on_n;
      lim_code <= (st_n == S_START && tmr_nx < BOOST_END) ? BOOST_CODE : LIM_1X;
      fault    <= (st_n == S_SEV) || (st_n == S_RETRY) || (st_n == S_HOT) ||
                  (st_n == S_LATCH) || (on_n && (oc || oc2x));
    end
  end
endmodule

// File: rtl/ilim_fault_seq_chk.sv
module ilim_fault_seq_chk
  import lim_seq_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic       oc2x,
  input logic       ovt,
  input logic       cool,
  input logic       clr,
  input logic       sw_on,
  input logic [1:0] lim_code,
  input logic       fault,
  input seq_st_t    st,
  input fmode_t     mode
);
  // R1
  clr_idle_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!sw_on && !fault && lim_code == 2'b00));

  // R2
  off_lim_chk: assert property (@(posedge clk) disable iff (rst)
    !sw_on |-> lim_code == 2'b00);

  // R9
  sev_off_chk: assert property (@(posedge clk) disable iff (rst)
    (sw_on && oc2x) |=> !sw_on);

  // R11
  off_fault_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(sw_on) && !$past(clr)) |-> fault);

  // R12
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!sw_on && !tick && !cool) |=> !sw_on);

  // R8
  cont_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == M_CONT && st == S_RUN && sw_on && !oc2x && !ovt && !clr) |=> sw_on);
endmodule

bind ilim_fault_seq ilim_fault_seq_chk u_chk (
  .clk(clk), .rst(rst), .tick(tick), .oc2x(oc2x), .ovt(ovt), .cool(cool),
  .clr(clr), .sw_on(sw_on), .lim_code(lim_code), .fault(fault),
  .st(st_q), .mode(mode_q)
);

// File: tb/sim_ilim_fault_seq.sv
module sim_ilim_fault_seq;
  logic clk = 1'b0, rst = 1'b1, tick = 1'b1, oc = 1'b0, oc2x = 1'b0;
  logic charged = 1'b1, ovt = 1'b0, cool = 1'b0, sel2 = 1'b0, sel1 = 1'b1, clr = 1'b0;
  logic sw_on, fault;
  logic [1:0] lim_code;

  always #4 clk = ~clk;

  ilim_fault_seq u0 (
    .clk(clk), .rst(rst), .tick(tick), .oc(oc), .oc2x(oc2x), .charged(charged),
    .ovt(ovt), .cool(cool), .sel2(sel2), .sel1(sel1), .clr(clr),
    .sw_on(sw_on), .lim_code(lim_code), .fault(fault)
  );

  typedef struct {
    logic       sw;
    logic [1:0] lim;
    logic       flt;
    int         dur;
    string      tag;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic expect_ev(input logic s, input logic [1:0] l, input logic f,
                           input int d, input string t);
    exp_t e;
    e.sw = s; e.lim = l; e.flt = f; e.dur = d; e.tag = t;
    q.push_back(e);
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic pulse_clr;
    clr = 1'b1; @(negedge clk); clr = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // restart after clr with boosted window, assuming charged is high
  task automatic restart_seq(input string t);
    expect_ev(0, 2'b00, 0, -1, t);
    expect_ev(1, 2'b10, 0, 6, "R1");
    expect_ev(1, 2'b00, 0, 4, "R2");
    pulse_clr();
    wait_cyc(30);
  endtask

  // monitor: compare each output change against the scoreboard
  initial begin
    logic [3:0] prev;
    int dc;
    prev = 4'b0;
    dc = 0;
    wait (!rst);
    forever begin
      @(negedge clk);
      dc++;
      if ({sw_on, lim_code, fault} != prev) begin
        n_chk++;
        if (q.size() == 0) begin
          n_fail++;
          $display("FAIL unexpected change: actual sw=%0b lim=%0b fault=%0b expected no change",
                   sw_on, lim_code, fault);
        end else begin
          exp_t e;
          e = q.pop_front();
          if (sw_on !== e.sw || lim_code !== e.lim || fault !== e.flt ||
              (e.dur >= 0 && dc != e.dur)) begin
            n_fail++;
            $display("FAIL %s: actual sw=%0b lim=%0b fault=%0b after %0d, expected sw=%0b lim=%0b fault=%0b after %0d",
                     e.tag, sw_on, lim_code, fault, dc, e.sw, e.lim, e.flt, e.dur);
          end
        end
        prev = {sw_on, lim_code, fault};
        dc = 0;
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      report();
    end
  end

  initial begin
    wait_cyc(4);
    n_chk++;  // R1 reset state
    if (sw_on !== 1'b0 || lim_code !== 2'b00 || fault !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: actual %0b%0b%0b expected 0000", sw_on, lim_code, fault);
    end

    // A: power-up in forced continuous, autoretry pins
    expect_ev(1, 2'b10, 0, -1, "R1");
    expect_ev(1, 2'b00, 0, 4, "R2");
    rst = 1'b0;
    wait_cyc(40);

    // B: R5 blanking count clears when the overcurrent goes away
    expect_ev(1, 2'b00, 1, -1, "R11");
    expect_ev(1, 2'b00, 0, 3, "R5");
    expect_ev(1, 2'b00, 1, 2, "R5");
    expect_ev(1, 2'b00, 0, 3, "R5");
    oc = 1; wait_cyc(3); oc = 0; wait_cyc(2);
    oc = 1; wait_cyc(3); oc = 0; wait_cyc(5);

    // C: autoretry cycle, with ticks paused during retry (R12)
    expect_ev(1, 2'b00, 1, -1, "R11");
    expect_ev(0, 2'b00, 1, 4, "R4");
    expect_ev(1, 2'b10, 1, 450, "R12");
    expect_ev(1, 2'b00, 1, 4, "R2");
    expect_ev(0, 2'b00, 1, 1, "R6");
    expect_ev(1, 2'b10, 0, 150, "R6");
    expect_ev(1, 2'b00, 0, 4, "R2");
    oc = 1;
    do @(negedge clk); while (sw_on);
    tick = 0; wait_cyc(300); tick = 1;
    do @(negedge clk); while (!sw_on);
    do @(negedge clk); while (sw_on);
    oc = 0;
    wait_cyc(190);

    // D: latchoff mode holds off until clr (R7), then startup timeout (R3)
    sel2 = 0; sel1 = 0;
    restart_seq("R1");
    expect_ev(1, 2'b00, 1, -1, "R11");
    expect_ev(0, 2'b00, 1, 4, "R7");
    oc = 1; wait_cyc(200); oc = 0; wait_cyc(20);
    charged = 0;
    expect_ev(0, 2'b00, 0, -1, "R7");
    expect_ev(1, 2'b10, 0, 6, "R1");
    expect_ev(1, 2'b00, 0, 4, "R2");
    expect_ev(0, 2'b00, 1, 12, "R3");
    pulse_clr();
    wait_cyc(60);
    charged = 1;

    // E: severe overcurrent in continuous mode (R9)
    sel2 = 1; sel1 = 0;
    restart_seq("R3");
    expect_ev(0, 2'b00, 1, -1, "R9");
    expect_ev(1, 2'b10, 0, 3, "R9");
    expect_ev(1, 2'b00, 0, 4, "R2");
    oc2x = 1; @(negedge clk); oc2x = 0;
    wait_cyc(30);

    // F: continuous mode rides through a long overcurrent (R8)
    expect_ev(1, 2'b00, 1, -1, "R8");
    expect_ev(1, 2'b00, 0, 100, "R8");
    oc = 1; wait_cyc(100); oc = 0; wait_cyc(5);

    // G: overtemperature in continuous mode (R10)
    expect_ev(0, 2'b00, 1, -1, "R10");
    expect_ev(0, 2'b00, 0, 10, "R10");
    expect_ev(1, 2'b10, 0, 6, "R10");
    expect_ev(1, 2'b00, 0, 4, "R2");
    ovt = 1; @(negedge clk); ovt = 0;
    wait_cyc(9);
    cool = 1; @(negedge clk); cool = 0;
    wait_cyc(30);

    // H: overtemperature in latchoff mode latches (R10)
    sel2 = 0; sel1 = 0;
    restart_seq("R4");
    expect_ev(0, 2'b00, 1, -1, "R10");
    ovt = 1; @(negedge clk); ovt = 0;
    wait_cyc(10);
    cool = 1; @(negedge clk); cool = 0;
    wait_cyc(20);

    // I: persisting severe overcurrent in latchoff mode (R9)
    restart_seq("R7");
    expect_ev(0, 2'b00, 1, -1, "R9");
    expect_ev(1, 2'b10, 1, 3, "R9");
    expect_ev(0, 2'b00, 1, 1, "R9");
    oc2x = 1; wait_cyc(20); oc2x = 0; wait_cyc(10);

    // J: overtemperature in autoretry mode (R10)
    sel2 = 0; sel1 = 1;
    restart_seq("R1");
    expect_ev(0, 2'b00, 1, -1, "R10");
    expect_ev(1, 2'b10, 0, 160, "R10");
    expect_ev(1, 2'b00, 0, 4, "R2");
    ovt = 1; @(negedge clk); ovt = 0;
    wait_cyc(9);
    cool = 1; @(negedge clk); cool = 0;
    wait_cyc(190);

    n_chk++;
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL %s: actual %0d events missing expected 0", q[0].tag, q.size());
    end
    done = 1;
    report();
  end
endmodule